// File: doc/BRIEF.md
# Configuration Startup and Readback Sequencer

This block steers a programmable device through its configuration life cycle. When it leaves reset, or when something outside pulls the completion pin low, it samples a 3-bit mode value and a readback policy. It then accepts a fixed number of configuration words. While it does so it holds two status outputs at their "configuration in progress" levels: one held high and one held low.

When the last word is accepted, startup runs in a fixed order. The user output enables turn on first. One clock cycle later the open-drain completion flag is released.

In user operation the sequencer watches two inputs, each through a two-flop synchroniser:

- A falling edge on the completion pin restarts the whole sequence from initialisation.
- A rising edge on the read trigger starts a readback of the stored configuration data. The data leaves serially, active low, on a pin that shares its place with a mode input.

The real bitstream is replaced by a word counter, and the stored data by a shift register that holds the most recent words.

Top module: `cfg_lifecycle_seq`

## Requirements
- R1: `mode_q` takes the value of `mode_pins` on the second clock edge after reset or re-initialisation ends. It keeps that value whatever `mode_pins` does afterwards, until the next re-initialisation.
- R2: While `user_oe` is low, `status_hi` is 1 and `status_lo_n` is 0. While `user_oe` is high, they follow `user_hi` and `user_lo`.
- R3: Configuration ends after CFG_WORDS words have been accepted. A word is accepted when `cfg_word_valid` is high in the configuration state. `user_oe` rises on the clock edge that accepts the last word and stays low before that.
- R4: `done_pull_low` is high until startup. It falls exactly one cycle after `user_oe` rises. `done_pu_en` equals the PULLUP parameter.
- R5: After completion, including during a readback, a High-to-Low change on `done_pin` sends the block back to initialisation. On the third clock edge after the change, `user_oe` and `rdata_oe` are 0 and `done_pull_low` is 1. A new configuration then follows.
- R6: After completion, a Low-to-High change on `rd_trig` starts a readback on the third clock edge. `rdata_oe` is then high for STORE_W cycles. In cycle i, `rdata_n` is the inverse of bit STORE_W-1-i of the store. The store holds the last STORE_W/WORD_W accepted words, with the newest in the low bits.
- R7: `rb_policy` is latched together with the mode. 2'b00 allows any number of readbacks. 2'b01 allows one readback per configuration. 2'b10 and 2'b11 inhibit readback.
- R8: A trigger edge that occurs during a readback is ignored and is not queued. Outside a readback, `rdata_oe` is 0 and `rdata_n` is 1.
- R9: While `rst_n` is low at a clock edge, the block enters idle: `user_oe` is 0, `done_pull_low` is 1 and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 3 | Mode value sampled before configuration |
| rb_policy | input | 2 | Readback policy, sampled with the mode |
| cfg_word_valid | input | 1 | Configuration word present |
| cfg_word | input | WORD_W | Configuration word |
| done_pin | input | 1 | Sensed level of the open-drain completion pin |
| rd_trig | input | 1 | Readback trigger (asynchronous) |
| user_hi | input | 1 | User value for the high-during-config status pin |
| user_lo | input | 1 | User value for the low-during-config status pin |
| mode_q | output | 3 | Latched configuration mode |
| status_hi | output | 1 | High while configuring, then user value |
| status_lo_n | output | 1 | Low while configuring, then user value |
| user_oe | output | 1 | User output enables |
| done_pull_low | output | 1 | Open-drain driver: 1 pulls the completion pin low |
| done_pu_en | output | 1 | Internal pull-up enable for the completion pin |
| rdata_oe | output | 1 | Readback data pin driven |
| rdata_n | output | 1 | Readback data, active low |

## Verification
A sequencer stuck in the wrong state shows up at once on `user_oe` and `done_pull_low`. Their order during startup exposes a skipped or merged startup step within one cycle. A wrong word count moves the rise of `user_oe` by whole cycles. A lost policy or used-once flag shows as a readback that appears, or fails to appear, three edges after a trigger. Wrong shift order or a wrong readback length is visible bit by bit on `rdata_n` and in how long `rdata_oe` stays high.

// File: rtl/cfgseq_pkg.sv
// Shared types for the configuration life-cycle sequencer.
package cfgseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE         = 3'd0,
        ST_SAMPLE_MODE  = 3'd1,
        ST_CONFIG       = 3'd2,
        ST_STARTUP_IO   = 3'd3,
        ST_STARTUP_DONE = 3'd4,
        ST_USER         = 3'd5,
        ST_READBACK     = 3'd6
    } seq_state_t;

    localparam logic [1:0] RB_UNLIMITED = 2'b00;
    localparam logic [1:0] RB_ONCE      = 2'b01;
endpackage

// File: rtl/cfgseq_edge_sync.sv
// Two-or-more flop synchroniser followed by an edge detector.
// Assumes din is asynchronous to clk; RISING picks which edge is reported.
// INIT is the level the chain takes in reset, so a pin at that level
// produces no edge when reset ends.
module cfgseq_edge_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0,
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the pin through the chain and remember the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{INIT}};
            prev  <= INIT;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = chain[STAGES-1] & ~prev;
        end else begin : g_fall
            assign edge_o = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/cfgseq_word_cnt.sv
// Counts accepted configuration words and keeps the most recent ones as
// readback data. Assumes clear and accept are never high together.
module cfgseq_word_cnt #(
    parameter int CFG_WORDS = 16,
    parameter int WORD_W    = 8,
    parameter int STORE_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               accept,
    input  logic [WORD_W-1:0]  word,
    output logic               last,
    output logic [STORE_W-1:0] store
);
    localparam int CNT_W = $clog2(CFG_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CFG_WORDS - 1);

    logic [CNT_W-1:0] cnt;

    assign last = accept && (cnt == LAST_IDX);

    // Word counter: restart on clear, advance on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    generate
        if (STORE_W > WORD_W) begin : g_multi
            // Shift each accepted word in from the low end.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store <= '0;
                end else if (accept) begin
                    store <= {store[STORE_W-WORD_W-1:0], word};
                end
            end
        end else begin : g_single
            // Store only the newest word (truncated to the store width).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store <= '0;
                end else if (accept) begin
                    store <= word[STORE_W-1:0];
                end
            end
        end
    endgenerate

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX);
endmodule

// File: rtl/cfgseq_readback.sv
// Serial readback engine: loads the store on start and shifts it out MSB
// first, one bit per clock, for STORE_W cycles. Abort stops it at once.
// Assumes start is only raised while the engine is idle.
module cfgseq_readback #(
    parameter int STORE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [STORE_W-1:0] store,
    output logic               busy,
    output logic               bit_out,
    output logic               finish
);
    localparam int CW = $clog2(STORE_W);
    localparam logic [CW-1:0] LAST_BIT = CW'(STORE_W - 1);

    logic [STORE_W-1:0] shreg;
    logic [CW-1:0]      bit_idx;

    assign bit_out = shreg[STORE_W-1];
    assign finish  = busy && (bit_idx == LAST_BIT);

    // Load, shift and count the readback bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            shreg   <= store;
            bit_idx <= '0;
        end else if (busy) begin
            if (abort || finish) begin
                busy <= 1'b0;
            end
            shreg   <= {shreg[STORE_W-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // R8
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/cfg_lifecycle_seq.sv
// Top of the configuration life-cycle sequencer. It samples the mode and
// readback policy, counts configuration words, sequences startup (output
// enables, then completion flag one cycle later), and in user operation
// reacts to a falling completion pin (re-initialise) and a rising read
// trigger (serial readback, active low). Assumes done_pin reflects the
// wired level of the open-drain completion pin.
module cfg_lifecycle_seq
    import cfgseq_pkg::*;
#(
    parameter int CFG_WORDS = 16,
    parameter int WORD_W    = 8,
    parameter int STORE_W   = 16,
    parameter int MODE_W    = 3,
    parameter int SYNC_LEN  = 2,
    parameter bit PULLUP    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic [1:0]        rb_policy,
    input  logic              cfg_word_valid,
    input  logic [WORD_W-1:0] cfg_word,
    input  logic              done_pin,
    input  logic              rd_trig,
    input  logic              user_hi,
    input  logic              user_lo,
    output logic [MODE_W-1:0] mode_q,
    output logic              status_hi,
    output logic              status_lo_n,
    output logic              user_oe,
    output logic              done_pull_low,
    output logic              done_pu_en,
    output logic              rdata_oe,
    output logic              rdata_n
);
    seq_state_t         state, state_nx;
    logic [1:0]         policy_q;
    logic               rb_used;
    logic               trig_rise, done_fall;
    logic               words_last, rb_busy, rb_bit, rb_finish;
    logic               rb_start, rb_allowed, accept;
    logic [STORE_W-1:0] store;

    cfgseq_edge_sync #(.STAGES(SYNC_LEN), .INIT(1'b0), .RISING(1'b1)) i_trig_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_trig), .edge_o(trig_rise));

    cfgseq_edge_sync #(.STAGES(SYNC_LEN), .INIT(1'b0), .RISING(1'b0)) i_done_sync (
        .clk(clk), .rst_n(rst_n), .din(done_pin), .edge_o(done_fall));

    assign accept = (state == ST_CONFIG) && cfg_word_valid;

    cfgseq_word_cnt #(.CFG_WORDS(CFG_WORDS), .WORD_W(WORD_W), .STORE_W(STORE_W)) i_words (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_SAMPLE_MODE),
        .accept(accept), .word(cfg_word), .last(words_last), .store(store));

    assign rb_allowed = (policy_q == RB_UNLIMITED) || ((policy_q == RB_ONCE) && !rb_used);
    assign rb_start   = (state == ST_USER) && !done_fall && trig_rise && rb_allowed;

    cfgseq_readback #(.STORE_W(STORE_W)) i_rb (
        .clk(clk), .rst_n(rst_n), .start(rb_start),
        .abort((state == ST_READBACK) && done_fall),
        .store(store), .busy(rb_busy), .bit_out(rb_bit), .finish(rb_finish));

    // Next-state selection for the life-cycle sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:         state_nx = ST_SAMPLE_MODE;
            ST_SAMPLE_MODE:  state_nx = ST_CONFIG;
            ST_CONFIG:       if (words_last) state_nx = ST_STARTUP_IO;
            ST_STARTUP_IO:   state_nx = ST_STARTUP_DONE;
            ST_STARTUP_DONE: state_nx = ST_USER;
            ST_USER: begin
                if (done_fall)     state_nx = ST_IDLE;
                else if (rb_start) state_nx = ST_READBACK;
            end
            ST_READBACK: begin
                if (done_fall)      state_nx = ST_IDLE;
                else if (rb_finish) state_nx = ST_USER;
            end
            default:         state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset into idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Latch mode and policy once per configuration; track readback use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            policy_q <= RB_UNLIMITED;
            rb_used  <= 1'b0;
        end else if (state == ST_SAMPLE_MODE) begin
            mode_q   <= mode_pins;
            policy_q <= rb_policy;
            rb_used  <= 1'b0;
        end else if (rb_start) begin
            rb_used  <= 1'b1;
        end
    end

    assign user_oe       = (state == ST_STARTUP_IO) || (state == ST_STARTUP_DONE) ||
                           (state == ST_USER) || (state == ST_READBACK);
    assign done_pull_low = !((state == ST_STARTUP_DONE) || (state == ST_USER) ||
                             (state == ST_READBACK));
    assign done_pu_en    = PULLUP;
    assign status_hi     = user_oe ? user_hi : 1'b1;
    assign status_lo_n   = user_oe ? user_lo : 1'b0;
    assign rdata_oe      = (state == ST_READBACK);
    assign rdata_n       = rdata_oe ? ~rb_bit : 1'b1;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIG) |=> $stable(mode_q));
    // R2
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !user_oe |-> (status_hi && !status_lo_n));
    // R4
    oe_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_oe) |=> $fell(done_pull_low));
    // R4
    done_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_pull_low) |-> $past(user_oe));
    // R7
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        policy_q[1] |-> !rb_busy);
    // R8
    rb_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> rb_busy);
    // R8
    rb_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_busy |-> rdata_oe);
    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!user_oe && done_pull_low && !rdata_oe));
endmodule

// File: tb/test_cfg_lifecycle_seq.sv
module test_cfg_lifecycle_seq;
    localparam int CFG_WORDS = 16;
    localparam int WORD_W    = 8;
    localparam int STORE_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_pins = 3'b000;
    logic [1:0]        rb_policy = 2'b00;
    logic              cfg_word_valid = 1'b0;
    logic [WORD_W-1:0] cfg_word = '0;
    logic              ext_pull = 1'b0;
    logic              rd_trig = 1'b0;
    logic              user_hi = 1'b0;
    logic              user_lo = 1'b0;
    logic [2:0]        mode_q;
    logic              status_hi, status_lo_n, user_oe, done_pull_low, done_pu_en;
    logic              rdata_oe, rdata_n;
    wire               done_pin = !(done_pull_low || ext_pull);

    int checks = 0;
    int errors = 0;
    logic [STORE_W-1:0] exp_store = '0;

    always #4 clk = ~clk;

    cfg_lifecycle_seq i_cfg_lifecycle_seq (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .rb_policy(rb_policy),
        .cfg_word_valid(cfg_word_valid), .cfg_word(cfg_word), .done_pin(done_pin),
        .rd_trig(rd_trig), .user_hi(user_hi), .user_lo(user_lo), .mode_q(mode_q),
        .status_hi(status_hi), .status_lo_n(status_lo_n), .user_oe(user_oe),
        .done_pull_low(done_pull_low), .done_pu_en(done_pu_en),
        .rdata_oe(rdata_oe), .rdata_n(rdata_n));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_rbit(input logic [STORE_W-1:0] s, input int i);
        return ~s[STORE_W-1-i];
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Called with the block in idle and mode/policy already on the pins.
    task automatic configure(input logic [2:0] mode);
        step();
        step();
        chk("R1 mode latched", mode_q, mode);
        mode_pins = ~mode;
        for (int w = 0; w < CFG_WORDS; w++) begin
            for (int g = $urandom_range(0, 3); g > 0; g--) begin
                cfg_word_valid = 1'b0;
                cfg_word = WORD_W'($urandom);
                step();
            end
            if (w == CFG_WORDS - 1) begin
                chk("R3 no early oe", user_oe, 0);
                chk("R2 busy hi", status_hi, 1);
                chk("R2 busy lo", status_lo_n, 0);
            end
            cfg_word_valid = 1'b1;
            cfg_word = WORD_W'($urandom);
            exp_store = {exp_store[STORE_W-WORD_W-1:0], cfg_word};
            step();
        end
        cfg_word_valid = 1'b0;
        chk("R3 oe after last word", user_oe, 1);
        chk("R4 done still low", done_pull_low, 1);
        user_hi = 1'($urandom);
        user_lo = 1'($urandom);
        #1;
        chk("R2 user hi", status_hi, user_hi);
        chk("R2 user lo", status_lo_n, user_lo);
        step();
        chk("R4 done released", done_pull_low, 0);
        step();
        chk("R1 mode held", mode_q, mode);
    endtask

    task automatic do_readback();
        rd_trig = 1'b1;
        step();
        step();
        chk("R6 not yet", rdata_oe, 0);
        step();
        for (int i = 0; i < STORE_W; i++) begin
            chk("R6 oe", rdata_oe, 1);
            chk("R6 bit", rdata_n, exp_rbit(exp_store, i));
            if (i == 4) rd_trig = 1'b0;
            if (i == 8) rd_trig = 1'b1;
            step();
        end
        for (int k = 0; k < 6; k++) begin
            chk("R8 ignored edge", rdata_oe, 0);
            chk("R8 idle data", rdata_n, 1);
            step();
        end
        rd_trig = 1'b0;
        repeat (3) step();
    endtask

    task automatic no_readback(input string req);
        rd_trig = 1'b1;
        for (int k = 0; k < STORE_W + 4; k++) begin
            chk(req, rdata_oe, 0);
            step();
        end
        chk(req, rdata_n, 1);
        rd_trig = 1'b0;
        repeat (3) step();
    endtask

    // Pull the completion pin low; leaves the block in idle.
    task automatic reinit(input logic [2:0] mode, input logic [1:0] pol);
        ext_pull = 1'b1;
        step();
        step();
        chk("R5 not yet", user_oe, 1);
        step();
        chk("R5 oe off", user_oe, 0);
        chk("R5 done pulled", done_pull_low, 1);
        chk("R5 rdata off", rdata_oe, 0);
        ext_pull = 1'b0;
        mode_pins = mode;
        rb_policy = pol;
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        mode_pins = 3'b101;
        rb_policy = 2'b00;
        repeat (3) step();
        chk("R9 reset oe", user_oe, 0);
        chk("R9 reset done", done_pull_low, 1);
        chk("R9 reset rdata", rdata_oe, 0);
        chk("R4 pullup", done_pu_en, 1);
        rst_n = 1'b1;
        configure(3'b101);
        do_readback();
        do_readback();

        reinit(3'b010, 2'b01);
        configure(3'b010);
        do_readback();
        no_readback("R7 once only");

        reinit(3'b111, 2'b10);
        configure(3'b111);
        no_readback("R7 inhibited");

        reinit(3'b011, 2'b00);
        configure(3'b011);
        rd_trig = 1'b1;
        repeat (5) step();
        chk("R6 started", rdata_oe, 1);
        reinit(3'b001, 2'b01);
        rd_trig = 1'b0;
        configure(3'b001);
        do_readback();

        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule